// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sets the refresh schedule for a DRAM with 512 rows. It does not drive the DRAM strobes. It tells the memory controller when a refresh cycle is due, through a request/acknowledge pair.

After reset the block waits a programmable settle time, at least 200 µs in real time. It then asks for a burst of eight wake-up refresh cycles. Once the last of those is acknowledged it raises `init_done`, and the controller may then let host traffic through. From then on, an interval timer adds one owed refresh every 8 ms / 512 (about 15.6 µs, given as clock cycles). The request stays high while any refresh is owed. Owed refreshes are counted up to a small ceiling, so a busy controller can catch up later. If no refresh is acknowledged for longer than the whole refresh window, the memory counts as having lost its contents. The block then drops `init_done` and requests the wake-up burst again.

The controller may use either refresh method. In CAS-before-RAS mode the memory keeps its own row counter. In RAS-only mode this block supplies the row address and steps it forward after each refresh.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is held and right after it, `ref_req` is 0, `init_done` is 0 and `ref_row` is 0.
- R2: `ref_req` first goes high exactly PAUSE_CYCLES clock edges after reset is released, and stays low before that.
- R3: During the wake-up burst, `ref_req` stays high until WAKE_CYCLES (8) acknowledges have been accepted. An acknowledge is accepted on a clock edge where both `ref_req` and `ref_ack` are 1.
- R4: `init_done` rises on the edge that accepts the final wake-up acknowledge. `ref_req` then falls, because nothing is owed yet.
- R5: An acknowledge given while `ref_req` is 0 is ignored. It does not move `ref_row`, and it does not cancel any refresh that becomes owed later.
- R6: When `ras_only_mode` is 1, each accepted acknowledge steps `ref_row` forward by one, wrapping from its all-ones value to 0. When `ras_only_mode` is 0, `ref_row` holds its value.
- R7: Once `init_done` is high, a refresh becomes owed every INTERVAL_CYCLES edges, counted from the edge where `init_done` rose. `ref_req` is high exactly while at least one refresh is owed, and each accepted acknowledge removes one.
- R8: The owed count stops at OWED_MAX. Further interval ticks are dropped, so OWED_MAX accepted acknowledges clear the request.
- R9: If LAPSE_CYCLES edges pass while `init_done` is high and no acknowledge is accepted, `init_done` falls and a new wake-up burst is requested (`ref_req` goes high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_only_mode | input | 1 | 1 = the row comes from `ref_row`; 0 = the memory's internal counter is used |
| ref_ack | input | 1 | The controller has carried out one refresh cycle |
| ref_req | output | 1 | A refresh cycle is wanted |
| ref_row | output | ROW_BITS | Row to refresh in RAS-only mode |
| init_done | output | 1 | Wake-up is complete and host access is allowed |

## Verification
The hardest case to reach is the lapse back into wake-up. It needs the owed count to reach its ceiling and then stay unserved for a long stretch, and before that the block must have passed through settle, wake-up and a run of normal refresh. The bench shrinks the pause, interval, ceiling and lapse window through parameters. It then follows a fixed, timed acknowledge script: first the ceiling is reached and cleared with exactly OWED_MAX acknowledges, then acknowledges are withheld until the lapse fires. After that, a second wake-up burst in CBR mode and a few more RAS-only refreshes drive the narrowed row counter through its wrap.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [1:0] {
        SEQ_SETTLE = 2'd0,
        SEQ_WAKE   = 2'd1,
        SEQ_RUN    = 2'd2
    } seq_state_t;

endpackage

// File: rtl/refresh_period_timer.sv
module refresh_period_timer #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (PERIOD <= 1) begin : g_every_cycle
            assign tick = run;
        end else begin : g_counter
            localparam int CW = $clog2(PERIOD);
            localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!run) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = run && (cnt_q == LAST);

            // R7
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
    parameter int OWED_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic add,
    input  logic settle,
    output logic pending
);
    localparam int DW = $clog2(OWED_MAX + 1);
    localparam logic [DW-1:0] CEIL = DW'(OWED_MAX);

    logic [DW-1:0] owed_d, owed_q;

    always_comb begin
        owed_d = owed_q;
        if (clear) begin
            owed_d = '0;
        end else begin
            case ({add, settle})
                2'b10:   if (owed_q != CEIL) owed_d = owed_q + 1'b1;
                2'b01:   if (owed_q != '0)   owed_d = owed_q - 1'b1;
                default: owed_d = owed_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owed_q <= '0;
        else        owed_q <= owed_d;
    end

    assign pending = (owed_q != '0);

    // R8
    owed_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= CEIL);
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
    parameter int ROW_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [ROW_BITS-1:0] row
);
    logic [ROW_BITS-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (step) row_d = row_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

    // R6
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(row_q));
endmodule

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer
    import dram_refresh_pkg::*;
#(
    parameter int PAUSE_CYCLES    = 20000,
    parameter int WAKE_CYCLES     = 8,
    parameter int INTERVAL_CYCLES = 1560,
    parameter int OWED_MAX        = 4,
    parameter int LAPSE_CYCLES    = 798720,
    parameter int ROW_BITS        = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_only_mode,
    input  logic                ref_ack,
    output logic                ref_req,
    output logic [ROW_BITS-1:0] ref_row,
    output logic                init_done
);
    localparam int PAUSE_W = $clog2(PAUSE_CYCLES);
    localparam int WAKE_W  = $clog2(WAKE_CYCLES + 1);
    localparam int LAPSE_W = $clog2(LAPSE_CYCLES);

    localparam logic [PAUSE_W-1:0] PAUSE_LAST = PAUSE_W'(PAUSE_CYCLES - 1);
    localparam logic [WAKE_W-1:0]  WAKE_LOAD  = WAKE_W'(WAKE_CYCLES);
    localparam logic [LAPSE_W-1:0] LAPSE_LAST = LAPSE_W'(LAPSE_CYCLES - 1);

    typedef struct packed {
        seq_state_t         state;
        logic [PAUSE_W-1:0] settle;
        logic [WAKE_W-1:0]  wake_left;
        logic [LAPSE_W-1:0] lapse;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic accepted;
    logic in_run;
    logic interval_tick;
    logic debt_pending;

    assign in_run   = (r_q.state == SEQ_RUN);
    assign ref_req  = (r_q.state == SEQ_WAKE) || (in_run && debt_pending);
    assign accepted = ref_req && ref_ack;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SEQ_SETTLE: begin
                if (r_q.settle == PAUSE_LAST) begin
                    r_d.state     = SEQ_WAKE;
                    r_d.wake_left = WAKE_LOAD;
                end else begin
                    r_d.settle = r_q.settle + 1'b1;
                end
            end
            SEQ_WAKE: begin
                if (accepted) begin
                    if (r_q.wake_left == WAKE_W'(1)) begin
                        r_d.state = SEQ_RUN;
                        r_d.lapse = '0;
                    end else begin
                        r_d.wake_left = r_q.wake_left - 1'b1;
                    end
                end
            end
            SEQ_RUN: begin
                if (accepted) begin
                    r_d.lapse = '0;
                end else if (r_q.lapse == LAPSE_LAST) begin
                    r_d.state     = SEQ_WAKE;
                    r_d.wake_left = WAKE_LOAD;
                    r_d.lapse     = '0;
                end else begin
                    r_d.lapse = r_q.lapse + 1'b1;
                end
            end
            default: r_d.state = SEQ_SETTLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= SEQ_SETTLE;
            r_q.settle    <= '0;
            r_q.wake_left <= '0;
            r_q.lapse     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    refresh_period_timer #(
        .PERIOD (INTERVAL_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_run),
        .tick  (interval_tick)
    );

    refresh_debt_counter #(
        .OWED_MAX (OWED_MAX)
    ) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!in_run),
        .add     (interval_tick),
        .settle  (accepted && in_run),
        .pending (debt_pending)
    );

    refresh_row_counter #(
        .ROW_BITS (ROW_BITS)
    ) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accepted && ras_only_mode),
        .row   (ref_row)
    );

    assign init_done = in_run;

    // R3 R7
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && !ref_ack |=> ref_req);

    // R4
    init_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(ref_req && ref_ack));

    // R5
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_req && ref_ack |=> $stable(ref_row));

    // R6
    cbr_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_only_mode |=> $stable(ref_row));

    // R9
    rewake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done) |-> ref_req);
endmodule

// File: tb/dram_refresh_sequencer_tb.sv
module dram_refresh_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PAUSE      = 20;
    localparam int INTERVAL   = 16;
    localparam int OWED_CAP   = 3;
    localparam int LAPSE      = 100;
    localparam int RB         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_only_mode = 1'b1;
    logic          ref_ack = 1'b0;
    logic          ref_req;
    logic [RB-1:0] ref_row;
    logic          init_done;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_refresh_sequencer #(
        .PAUSE_CYCLES    (PAUSE),
        .WAKE_CYCLES     (8),
        .INTERVAL_CYCLES (INTERVAL),
        .OWED_MAX        (OWED_CAP),
        .LAPSE_CYCLES    (LAPSE),
        .ROW_BITS        (RB)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ras_only_mode (ras_only_mode),
        .ref_ack       (ref_ack),
        .ref_req       (ref_req),
        .ref_row       (ref_row),
        .init_done     (init_done)
    );

    // run table: {wait[7:0], ack, exp_req, exp_init, exp_row[3:0]}
    localparam int NV = 11;
    localparam logic [14:0] RUN_VEC [NV] = '{
        {8'd15, 1'b0, 1'b0, 1'b1, 4'd8},   // R7 nothing owed yet
        {8'd1,  1'b0, 1'b1, 1'b1, 4'd8},   // R7 first tick
        {8'd0,  1'b1, 1'b0, 1'b1, 4'd9},   // R7 R6 ack clears
        {8'd15, 1'b0, 1'b1, 1'b1, 4'd9},   // R7 second tick
        {8'd16, 1'b0, 1'b1, 1'b1, 4'd9},   // R7 two owed
        {8'd0,  1'b1, 1'b1, 1'b1, 4'd10},  // R7 one left
        {8'd0,  1'b1, 1'b0, 1'b1, 4'd11},  // R7 cleared
        {8'd62, 1'b0, 1'b1, 1'b1, 4'd11},  // R8 four ticks, capped
        {8'd0,  1'b1, 1'b1, 1'b1, 4'd12},  // R8
        {8'd0,  1'b1, 1'b1, 1'b1, 4'd13},  // R8
        {8'd0,  1'b1, 1'b0, 1'b1, 4'd14}   // R8 cap of three cleared
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ack_pulse();
        ref_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ref_ack = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 req", 16'(ref_req), 16'd0);
        check("R1 init", 16'(init_done), 16'd0);
        check("R1 row", 16'(ref_row), 16'd0);
        rst_n = 1'b1;

        // R5: ack during settle is ignored
        ack_pulse();
        wait_edges(18);
        check("R2 req low before pause", 16'(ref_req), 16'd0);
        check("R5 row after idle ack", 16'(ref_row), 16'd0);
        wait_edges(1);
        check("R2 req at pause", 16'(ref_req), 16'd1);
        check("R1 init still low", 16'(init_done), 16'd0);

        // R3 wake burst, RAS-only
        for (int i = 1; i <= 7; i++) begin
            ack_pulse();
            check("R3 req held", 16'(ref_req), 16'd1);
            check("R3 init low", 16'(init_done), 16'd0);
        end
        check("R6 row steps", 16'(ref_row), 16'd7);
        ack_pulse();
        check("R4 init rises", 16'(init_done), 16'd1);
        check("R4 req drops", 16'(ref_req), 16'd0);
        check("R6 row eight", 16'(ref_row), 16'd8);

        for (int v = 0; v < NV; v++) begin
            if (RUN_VEC[v][6]) ack_pulse();
            else wait_edges(int'(RUN_VEC[v][14:7]));
            check($sformatf("R7/R8 vec%0d req", v), 16'(ref_req), 16'(RUN_VEC[v][5]));
            check($sformatf("R7/R8 vec%0d init", v), 16'(init_done), 16'(RUN_VEC[v][4]));
            check($sformatf("R6 vec%0d row", v), 16'(ref_row), 16'(RUN_VEC[v][3:0]));
        end

        // R9 lapse: last accepted ack at t=115, lapse fires at t=215
        wait_edges(99);
        check("R9 init before lapse", 16'(init_done), 16'd1);
        wait_edges(1);
        check("R9 init falls", 16'(init_done), 16'd0);
        check("R9 wake requested", 16'(ref_req), 16'd1);

        // second burst in CBR mode: row held
        ras_only_mode = 1'b0;
        for (int i = 1; i <= 8; i++) ack_pulse();
        check("R4 init after rewake", 16'(init_done), 16'd1);
        check("R6 CBR row held", 16'(ref_row), 16'd14);

        // R5 ack with req low in RUN
        ras_only_mode = 1'b1;
        ack_pulse();
        check("R5 req stays low", 16'(ref_req), 16'd0);
        check("R5 row unchanged", 16'(ref_row), 16'd14);
        wait_edges(15);
        check("R5 tick not cancelled", 16'(ref_req), 16'd1);
        ack_pulse();
        check("R6 row fifteen", 16'(ref_row), 16'd15);
        check("R7 cleared", 16'(ref_req), 16'd0);
        wait_edges(15);
        check("R7 next tick", 16'(ref_req), 16'd1);
        ack_pulse();
        check("R6 row wraps", 16'(ref_row), 16'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule